// File: doc/BRIEF.md
# PCI Interrupt Line Steering Unit

This unit steers four level-sensitive PCI interrupt request lines onto sixteen legacy ISA interrupt inputs of an interrupt controller. Each PCI line owns one byte-wide steering register. A value below sixteen selects an ISA line. Any larger value turns the line off.

Software programs the steering bytes through a small configuration window. One access moves one to four bytes, starting at a byte address. Any number of PCI lines may be steered to the same ISA line, and that ISA output is then the OR of their levels. The unit keeps one tracked level bit for every pairing of an ISA line with a PCI line. When a write changes the steering, all tracked bits are rebuilt at once from the live input levels.

For each PCI line, a status output gives its enable flag and the ISA line it selects, so the interrupt mapping can be read without a configuration access.

Top module: `pirq_steer`

## Requirements
- R1: The steering byte for PCI line p (p = 0..3) sits at configuration byte address 0x60+p. Bytes at any other address read as zero, and writes to them change no state and no output.
- R2: Synchronous active-high reset sets all four steering bytes to 0x80, clears every tracked level, drives all sixteen ISA outputs low and reports every line as disabled.
- R3: A steering byte below 16 routes its PCI line to that ISA number. A byte of 16 or more disables the line, and a disabled line drives no ISA output, even while its input is high.
- R4: Each ISA output is high exactly when at least one enabled PCI line steered to it had a high input at the last clock edge. Lines sharing an ISA line combine as a wired-OR.
- R5: The ISA outputs are registered. A change on a PCI input level appears on the outputs at the first rising edge that samples it, and not before.
- R6: A write whose byte range overlaps 0x60..0x63 rebuilds all tracked levels from the current inputs. The outputs show the new steering after the same edge that captures the write, and a line that moves away stops driving its old ISA line.
- R7: route_en[p] is 1 when steering byte p is below 16, and route_num[4p+3:4p] then holds the ISA number. When the line is disabled, route_en[p] is 0 and route_num[4p+3:4p] is 4'hF.
- R8: A write of cfg_size bytes (1 to 4) puts cfg_wdata byte i at address cfg_addr+i for i < cfg_size. Data bytes at or beyond cfg_size are not written.
- R9: cfg_rdata is combinational. Byte i holds the register at cfg_addr+i for i < cfg_size, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per access |
| cfg_addr | input | 8 | Byte address of the first byte of the access |
| cfg_size | input | 3 | Number of bytes in the access, 1 to 4 |
| cfg_wdata | input | 32 | Write data, byte i goes to cfg_addr+i |
| cfg_rdata | output | 32 | Read data, byte i comes from cfg_addr+i |
| pci_lvl | input | 4 | Current PCI interrupt levels, bit p for line p |
| isa_irq | output | 16 | Registered ISA interrupt levels |
| route_en | output | 4 | Per PCI line: steering enabled |
| route_num | output | 16 | Per PCI line: 4-bit ISA number, 4'hF when disabled |

## Verification
ISA outputs are due one rising edge after the cycle in which a PCI level or a steering write is presented. Steering status follows the write on that same edge. Read data is valid in the same cycle as the address. The bench drives inputs at the falling edge and advances its reference model at each rising edge. It compares the outputs a few nanoseconds after that edge, so each result is sampled in the cycle it becomes due. Separate checks look just before an edge to confirm that nothing moves early. They cover shared lines, a line rerouted while its input is held high, and a line disabled while asserted.

// File: rtl/pirq_steer.sv
module pirq_steer #(
  parameter int NPIN  = 4,
  parameter int NISA  = 16,
  parameter int BASE  = 'h60,
  parameter logic [7:0] RSTV = 8'h80,
  localparam int ISAW = $clog2(NISA)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_addr,
  input  logic [2:0]           cfg_size,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic [NPIN-1:0]      pci_lvl,
  output logic [NISA-1:0]      isa_irq,
  output logic [NPIN-1:0]      route_en,
  output logic [NPIN*ISAW-1:0] route_num
);
  localparam int NTRK = NISA * NPIN;

  logic [7:0]      rte    [NPIN];
  logic [7:0]      rte_nx [NPIN];
  logic [NTRK-1:0] track, track_nx;
  logic [NISA-1:0] isa_nx;
  logic            hit;

  always_comb begin
    rte_nx    = rte;
    hit       = 1'b0;
    cfg_rdata = '0;
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < NPIN; p++) begin
        if (i < int'(cfg_size) && int'(cfg_addr) + i == BASE + p) begin
          cfg_rdata[8*i +: 8] = rte[p];
          if (cfg_we) begin
            rte_nx[p] = cfg_wdata[8*i +: 8];
            hit       = 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    track_nx = hit ? '0 : track;
    for (int p = 0; p < NPIN; p++) begin
      if (hit) begin
        if (int'(rte_nx[p]) < NISA)
          track_nx[int'(rte_nx[p][ISAW-1:0]) * NPIN + p] = pci_lvl[p];
      end else if (int'(rte[p]) < NISA) begin
        track_nx[int'(rte[p][ISAW-1:0]) * NPIN + p] = pci_lvl[p];
      end
    end
    for (int n = 0; n < NISA; n++)
      isa_nx[n] = |track_nx[n*NPIN +: NPIN];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NPIN; p++) rte[p] <= RSTV;
      track   <= '0;
      isa_irq <= '0;
    end else begin
      rte     <= rte_nx;
      track   <= track_nx;
      isa_irq <= isa_nx;
    end
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [NISA-1:0] col;
    for (genvar n = 0; n < NISA; n++) begin : g_col
      assign col[n] = track[n*NPIN + p];
    end
    assign route_en[p] = int'(rte[p]) < NISA;
    assign route_num[p*ISAW +: ISAW] = route_en[p] ? rte[p][ISAW-1:0] : '1;

    // R3: a disabled line holds no tracked level anywhere
    a_r3_off_silent: assert property (@(posedge clk) disable iff (rst)
      !route_en[p] |-> (col == '0));

    // R4: a high enabled line forces its target output high
    a_r4_src_drives: assert property (@(posedge clk) disable iff (rst)
      (route_en[p] && $past(pci_lvl[p])) |-> isa_irq[route_num[p*ISAW +: ISAW]]);
  end

  // R2: outputs quiet and all lines disabled right after reset
  a_r2_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (isa_irq == '0 && route_en == '0));

  // R5: without steering writes, unchanged inputs keep outputs unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!hit && $stable(pci_lvl)) |=> $stable(isa_irq));
endmodule

// File: tb/sim_pirq_steer.sv
module sim_pirq_steer;
  logic        clk = 0, rst = 1, cfg_we = 0;
  logic [7:0]  cfg_addr = 0;
  logic [2:0]  cfg_size = 1;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic [3:0]  pci_lvl = 0, route_en;
  logic [15:0] isa_irq, route_num;

  int total = 0, bad = 0;
  int mr [4];
  logic [15:0] exp_isa;
  bit done = 0;

  pirq_steer u0 (.clk, .rst, .cfg_we, .cfg_addr, .cfg_size, .cfg_wdata,
                 .cfg_rdata, .pci_lvl, .isa_irq, .route_en, .route_num);

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd(int a, int sz);
    logic [31:0] v = 0;
    for (int i = 0; i < sz; i++)
      if (a + i >= 'h60 && a + i <= 'h63) v[8*i +: 8] = 8'(mr[a + i - 'h60]);
    return v;
  endfunction

  function automatic logic [15:0] exp_num();
    logic [15:0] v;
    for (int p = 0; p < 4; p++) v[4*p +: 4] = (mr[p] < 16) ? 4'(mr[p]) : 4'hF;
    return v;
  endfunction

  function automatic logic [3:0] exp_en();
    logic [3:0] v;
    for (int p = 0; p < 4; p++) v[p] = mr[p] < 16;
    return v;
  endfunction

  // reference model: steering bytes and wired-OR of live levels
  always @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < 4; p++) mr[p] = 'h80;
      exp_isa = 0;
    end else begin
      if (cfg_we)
        for (int i = 0; i < int'(cfg_size); i++)
          if (int'(cfg_addr) + i >= 'h60 && int'(cfg_addr) + i <= 'h63)
            mr[int'(cfg_addr) + i - 'h60] = int'(cfg_wdata[8*i +: 8]);
      exp_isa = 0;
      for (int p = 0; p < 4; p++)
        if (mr[p] < 16 && pci_lvl[p]) exp_isa[mr[p]] = 1'b1;
    end
    #3;
    if (!rst && !done) begin
      chk("R4,R5,R6 isa_irq", 32'(isa_irq), 32'(exp_isa));
      chk("R7 route_en", 32'(route_en), 32'(exp_en()));
      chk("R7 route_num", 32'(route_num), 32'(exp_num()));
    end
  end

  task automatic wr(int a, int sz, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = 8'(a); cfg_size = 3'(sz); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = 0;
  endtask

  task automatic rd(int a, int sz, string tag);
    @(negedge clk);
    cfg_addr = 8'(a); cfg_size = 3'(sz);
    #1 chk(tag, cfg_rdata, exp_rd(a, sz));
  endtask

  task automatic lvl(logic [3:0] v);
    @(negedge clk);
    pci_lvl = v;
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R2 isa after reset", 32'(isa_irq), 0);
    chk("R2 route_en after reset", 32'(route_en), 0);
    chk("R2 route_num after reset", 32'(route_num), 32'hFFFF);
    rd('h60, 4, "R2 reset bytes");
    chk("R2 reset bytes literal", cfg_rdata, 32'h80808080);

    // disabled lines drive nothing
    lvl(4'hF);
    @(negedge clk);
    chk("R3 disabled high inputs", 32'(isa_irq), 0);
    lvl(4'h0);

    // sharing: lines 0 and 1 on ISA 5
    wr('h60, 1, 32'h05);
    wr('h61, 1, 32'h05);
    lvl(4'b0001);
    #1 chk("R5 not before edge", 32'(isa_irq), 0);
    @(negedge clk);
    chk("R4 line0 on 5", 32'(isa_irq), 32'h0020);
    lvl(4'b0011);
    lvl(4'b0010);
    @(negedge clk);
    chk("R4 shared line1 holds 5", 32'(isa_irq), 32'h0020);
    lvl(4'b0000);
    @(negedge clk);
    chk("R4 shared released", 32'(isa_irq), 0);

    // reroute while held high
    lvl(4'b0001);
    @(negedge clk);
    wr('h60, 1, 32'h09);
    chk("R6 moved to 9", 32'(isa_irq), 32'h0200);

    // disable while asserted
    wr('h60, 1, 32'h10);
    chk("R3 disabled while high", 32'(isa_irq), 0);
    chk("R7 disabled status", 32'(route_num[3:0]), 32'hF);

    // multi-byte write and reads
    wr('h60, 4, 32'h0F030C01);
    rd('h60, 4, "R8 four-byte write");
    chk("R1 byte layout", cfg_rdata, 32'h0F030C01);
    wr('h62, 2, 32'hAABB0707);
    rd('h62, 4, "R9 read past window");
    chk("R8 size two", cfg_rdata, 32'h00000707);
    wr('h5F, 4, 32'h02030444);
    rd('h60, 4, "R8 straddling write");
    chk("R1 straddle literal", cfg_rdata, 32'h07020304);
    wr('h64, 2, 32'h0000_0101);
    rd('h60, 4, "R1 outside write ignored");
    rd('h64, 2, "R1 outside reads zero");
    chk("R1 outside literal", cfg_rdata, 0);
    rd('h61, 1, "R9 single byte");

    // random traffic
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      pci_lvl = 4'($urandom);
      if ($urandom_range(0, 3) == 0) begin
        cfg_we = 1;
        cfg_addr = 8'($urandom_range('h5C, 'h66));
        cfg_size = 3'($urandom_range(1, 4));
        cfg_wdata = $urandom & 32'h1F1F1F1F;
      end else cfg_we = 0;
    end
    @(negedge clk);
    cfg_we = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule